// File: doc/BRIEF.md
# Card Detect Debounce and Interrupt Request

This block watches the mechanical switch of a smart-card connector. It decides from that switch whether a card is seated, and it raises an interrupt toward the host controller whenever that state changes. The raw switch level first passes through a two-flop synchronizer. It then goes to a digital filter that counts microsecond ticks. A new level is accepted only when it has held without a break for the full filter window, so contact bounce and short glitches are discarded. Bounce is filtered the same way on insertion and on extraction.

The switch may be wired normally open, where the pin is pulled high and a seated card pulls it low. It may also be wired normally closed, where the pin goes high when a card is seated. A polarity input selects which level counts as "card present". The interrupt output is active low and is meant to drive an open-drain pad, so several card slots can share one host interrupt line. The interrupt is also asserted by a rising card-supply overload flag. The host releases the interrupt by raising chip select, or by raising power-on while chip select is held low.

Top module: `cdet_irq_top`

## Requirements
- R1: A change of the synchronized detect level is accepted only after it has persisted for FILTER_TICKS consecutive tick_us_i pulses (default 100). Any cycle in which the synchronized level agrees with the accepted level restarts the count, so a shorter excursion changes neither output.
- R2: The detect pin passes through a two-flop synchronizer. Both outputs change on the clock edge after the one on which the filter accepts a new level, and the bench model tracks them on every cycle.
- R3: With pol_closed_i = 0 (normally open), an accepted low level means a card is present. With pol_closed_i = 1 (normally closed), an accepted high level means a card is present.
- R4: Every accepted change of the filtered level, whether insertion or extraction, drives irq_n_o to 0.
- R5: A 0-to-1 transition of cs_n_i drives irq_n_o back to 1. Holding cs_n_i low does not release it.
- R6: A 0-to-1 transition of pwr_on_i releases irq_n_o only while cs_n_i is 0. With cs_n_i at 1 the same transition leaves irq_n_o at 0.
- R7: A 0-to-1 transition of vcc_ovl_i drives irq_n_o to 0. An overload flag that stays high after a release does not assert the interrupt again.
- R8: When an assertion cause and a release edge fall in the same cycle, irq_n_o is 0 afterwards.
- R9: A change of pol_closed_i alone flips card_present_o on the next edge, but it does not assert irq_n_o, so a card already seated at that moment is never reported.
- R10: After synchronous reset, card_present_o is 0 and irq_n_o is 1, and the filtered level is taken to be high (no card for a normally-open switch).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_us_i | input | 1 | One-cycle strobe, once per microsecond |
| det_pin_i | input | 1 | Raw connector switch level, asynchronous |
| pol_closed_i | input | 1 | 0: normally-open switch, 1: normally-closed switch |
| vcc_ovl_i | input | 1 | Card-supply overload flag, synchronous |
| cs_n_i | input | 1 | Chip select, active low, already synchronized |
| pwr_on_i | input | 1 | Card power request, already synchronized |
| card_present_o | output | 1 | Registered card-present state |
| irq_n_o | output | 1 | Registered active-low interrupt, 0 = pull pad low |

## Verification
The assertions assume that tick_us_i is a single-cycle strobe, and that cs_n_i, pwr_on_i, vcc_ovl_i and pol_closed_i are already synchronous to clk_i and free of X after reset. Only det_pin_i may be asynchronous. The stimulus respects this by changing every input on the falling clock edge and by generating the tick as a one-cycle pulse every fifth clock. Detect pulses are held for whole numbers of clocks chosen well inside or well outside the filter window, so that tick alignment cannot tip a case across the boundary. Release edges are produced as clean level steps on chip select and power-on.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

  typedef enum logic {
    SW_NORM_OPEN   = 1'b0,
    SW_NORM_CLOSED = 1'b1
  } sw_kind_e;

  localparam int unsigned DEF_FILTER_TICKS = 100;
  localparam int unsigned DEF_SYNC_STAGES  = 2;

endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= RST_VAL;
        else       stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= {STAGES{RST_VAL}};
        else       stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cdet_filter.sv
module cdet_filter #(
  parameter int unsigned LIMIT     = 100,
  parameter logic        RST_LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic level_i,
  output logic level_o,
  output logic accept_o
);

  localparam int unsigned CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          acc_q;
  logic          differs;

  assign differs = (level_i != lvl_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= '0;
      lvl_q <= RST_LEVEL;
      acc_q <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      if (!differs) begin
        run_q <= '0;
      end else if (tick_i) begin
        if (run_q == LAST) begin
          lvl_q <= level_i;
          run_q <= '0;
          acc_q <= 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign level_o  = lvl_q;
  assign accept_o = acc_q;

  AST_RUN_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i) // R1
    run_q <= LAST);

  AST_ACCEPT_FULL_RUN: assert property (@(posedge clk_i) disable iff (rst_i) // R1
    acc_q |-> ($past(run_q) == LAST && $past(tick_i)));

  AST_LEVEL_MOVES_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i) // R4
    (lvl_q != $past(lvl_q)) |-> acc_q);

endmodule

// File: rtl/cdet_irq.sv
module cdet_irq (
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  input  logic ovl_i,
  input  logic cs_n_i,
  input  logic pwr_on_i,
  output logic irq_n_o
);

  logic cs_d_q;
  logic pwr_d_q;
  logic ovl_d_q;
  logic irq_n_q;
  logic raise_w;
  logic release_w;

  assign raise_w   = evt_i | (ovl_i & ~ovl_d_q);
  assign release_w = (cs_n_i & ~cs_d_q) | (pwr_on_i & ~pwr_d_q & ~cs_n_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cs_d_q  <= 1'b1;
      pwr_d_q <= 1'b0;
      ovl_d_q <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      cs_d_q  <= cs_n_i;
      pwr_d_q <= pwr_on_i;
      ovl_d_q <= ovl_i;
      if (raise_w)        irq_n_q <= 1'b0;
      else if (release_w) irq_n_q <= 1'b1;
    end
  end

  assign irq_n_o = irq_n_q;

  AST_EVENT_PULLS_LOW: assert property (@(posedge clk_i) disable iff (rst_i) // R4
    evt_i |=> !irq_n_o);

  AST_OVERLOAD_EDGE_LOW: assert property (@(posedge clk_i) disable iff (rst_i) // R7
    (ovl_i && !ovl_d_q) |=> !irq_n_o);

  AST_CS_RISE_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i) // R5
    (cs_n_i && !cs_d_q && !evt_i && !(ovl_i && !ovl_d_q)) |=> irq_n_o);

  AST_PWR_RISE_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i) // R6
    (pwr_on_i && !pwr_d_q && !cs_n_i && !evt_i && !(ovl_i && !ovl_d_q)) |=> irq_n_o);

  AST_PWR_IGNORED_DESELECTED: assert property (@(posedge clk_i) disable iff (rst_i) // R6
    (!irq_n_o && cs_n_i && cs_d_q) |=> !irq_n_o);

  AST_RAISE_BEATS_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i) // R8
    (evt_i && cs_n_i && !cs_d_q) |=> !irq_n_o);

endmodule

// File: rtl/cdet_irq_top.sv
module cdet_irq_top
  import cdet_pkg::*;
#(
  parameter int unsigned FILTER_TICKS = DEF_FILTER_TICKS,
  parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
  parameter logic        IDLE_LEVEL   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_us_i,
  input  logic det_pin_i,
  input  logic pol_closed_i,
  input  logic vcc_ovl_i,
  input  logic cs_n_i,
  input  logic pwr_on_i,
  output logic card_present_o,
  output logic irq_n_o
);

  logic     det_sync;
  logic     det_level;
  logic     det_accept;
  sw_kind_e sw_kind;
  logic     present_q;

  assign sw_kind = sw_kind_e'(pol_closed_i);

  cdet_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_LEVEL)
  ) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (det_pin_i),
    .q_o   (det_sync)
  );

  cdet_filter #(
    .LIMIT     (FILTER_TICKS),
    .RST_LEVEL (IDLE_LEVEL)
  ) u_filter (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick_us_i),
    .level_i  (det_sync),
    .level_o  (det_level),
    .accept_o (det_accept)
  );

  cdet_irq u_irq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .evt_i    (det_accept),
    .ovl_i    (vcc_ovl_i),
    .cs_n_i   (cs_n_i),
    .pwr_on_i (pwr_on_i),
    .irq_n_o  (irq_n_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) present_q <= 1'b0;
    else       present_q <= (sw_kind == SW_NORM_CLOSED) ? det_level : ~det_level;
  end

  assign card_present_o = present_q;

  AST_POLARITY_ALONE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i) // R9
    (irq_n_o && !det_accept && !vcc_ovl_i) |=> irq_n_o);

endmodule

// File: tb/sim_cdet_irq_top.sv
module sim_cdet_irq_top;

  localparam int TICKS = 100;
  localparam int TDIV  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic det_raw = 1'b1;
  logic pol_nc = 1'b0;
  logic ovl = 1'b0;
  logic cs_n = 1'b1;
  logic pwr_on = 1'b0;
  logic card_present;
  logic irq_n;

  always #10 clk = ~clk;

  cdet_irq_top u0 (
    .clk_i          (clk),
    .rst_i          (rst),
    .tick_us_i      (tick),
    .det_pin_i      (det_raw),
    .pol_closed_i   (pol_nc),
    .vcc_ovl_i      (ovl),
    .cs_n_i         (cs_n),
    .pwr_on_i       (pwr_on),
    .card_present_o (card_present),
    .irq_n_o        (irq_n)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R10";

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_out(string req, logic pres, logic irq);
    chk({req, " card_present"}, card_present, pres);
    chk({req, " irq_n"}, irq_n, irq);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int tdiv = 0;
  always @(negedge clk) begin
    if (tdiv == TDIV - 1) begin
      tdiv <= 0;
      tick <= 1'b1;
    end else begin
      tdiv <= tdiv + 1;
      tick <= 1'b0;
    end
  end

  // Behavioural reference: delay line as a queue, run length as an integer.
  bit m_q[$];
  bit m_lvl = 1'b1;
  int m_run = 0;
  bit m_acc = 1'b0;
  bit m_pres = 1'b0;
  bit m_irq = 1'b1;
  bit m_cs_d = 1'b1;
  bit m_pw_d = 1'b0;
  bit m_ov_d = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_q.push_back(1'b1);
      m_q.push_back(1'b1);
      m_lvl = 1'b1; m_run = 0; m_acc = 1'b0; m_pres = 1'b0; m_irq = 1'b1;
      m_cs_d = 1'b1; m_pw_d = 1'b0; m_ov_d = 1'b0;
    end else begin
      bit up;
      bit down;
      bit seen;
      up   = m_acc || (ovl && !m_ov_d);
      down = (cs_n && !m_cs_d) || (pwr_on && !m_pw_d && !cs_n);
      if (up) m_irq = 1'b0;
      else if (down) m_irq = 1'b1;
      m_pres = pol_nc ? m_lvl : !m_lvl;
      m_acc = 1'b0;
      seen = m_q.pop_front();
      if (seen != m_lvl) begin
        if (tick) begin
          m_run++;
          if (m_run == TICKS) begin
            m_lvl = seen;
            m_run = 0;
            m_acc = 1'b1;
          end
        end
      end else begin
        m_run = 0;
      end
      m_q.push_back(det_raw);
      m_cs_d = cs_n; m_pw_d = pwr_on; m_ov_d = ovl;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({"R2 model ", cur_req, " present"}, card_present, m_pres);
      chk({"R2 model ", cur_req, " irq"}, irq_n, m_irq);
    end
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    expect_out("R10 reset", 1'b0, 1'b1);

    cur_req = "R1";
    det_raw = 1'b0; cyc(300);
    det_raw = 1'b1; cyc(800);
    expect_out("R1 short glitch", 1'b0, 1'b1);

    cur_req = "R3 R4";
    det_raw = 1'b0; cyc(700);
    expect_out("R3 R4 open-switch insertion", 1'b1, 1'b0);

    cur_req = "R5";
    cs_n = 1'b0; cyc(3);
    expect_out("R5 cs held low", 1'b1, 1'b0);
    cs_n = 1'b1; cyc(2);
    expect_out("R5 cs rise", 1'b1, 1'b1);

    cur_req = "R4";
    det_raw = 1'b1; cyc(700);
    expect_out("R4 extraction", 1'b0, 1'b0);

    cur_req = "R6";
    pwr_on = 1'b1; cyc(3);
    expect_out("R6 pwr rise deselected", 1'b0, 1'b0);
    pwr_on = 1'b0; cs_n = 1'b0; cyc(2);
    pwr_on = 1'b1; cyc(2);
    expect_out("R6 pwr rise selected", 1'b0, 1'b1);
    cs_n = 1'b1; pwr_on = 1'b0; cyc(2);

    cur_req = "R7";
    ovl = 1'b1; cyc(2);
    expect_out("R7 overload", 1'b0, 1'b0);
    cs_n = 1'b0; cyc(2);
    cs_n = 1'b1; cyc(2);
    cyc(5);
    expect_out("R7 held overload after release", 1'b0, 1'b1);
    ovl = 1'b0; cyc(2);

    cur_req = "R8";
    cs_n = 1'b0; cyc(2);
    ovl = 1'b1; cs_n = 1'b1; cyc(2);
    expect_out("R8 coincident raise and release", 1'b0, 1'b0);
    cs_n = 1'b0; cyc(2);
    cs_n = 1'b1; cyc(2);
    ovl = 1'b0; cyc(2);
    expect_out("R8 cleared afterwards", 1'b0, 1'b1);

    cur_req = "R9";
    pol_nc = 1'b1; cyc(3);
    expect_out("R9 polarity flip", 1'b1, 1'b1);
    cyc(600);
    expect_out("R9 no late report", 1'b1, 1'b1);

    cur_req = "R3";
    det_raw = 1'b0; cyc(700);
    expect_out("R3 closed-switch extraction", 1'b0, 1'b0);
    cs_n = 1'b0; cyc(2);
    cs_n = 1'b1; cyc(2);

    cur_req = "R1";
    det_raw = 1'b1; cyc(450);
    det_raw = 1'b0; cyc(10);
    det_raw = 1'b1; cyc(450);
    expect_out("R1 restarted run", 1'b0, 1'b1);
    cyc(200);
    expect_out("R1 long run accepted", 1'b1, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule